// File: doc/BRIEF.md
# Interrupt Queue Writer

This block gathers interrupt status words from two internal sources and stores them, one after another, in a circular queue that lives in host memory. One source reports that an action request has been acknowledged. The other reports that a frame has completed on a numbered channel. Each stored word leaves the block through a simple memory write port. The block holds the write until the memory side accepts it. Once a write completes, the block pulses an interrupt line toward the host.

The queue is defined by a base byte address and a block count. A queue holds (count + 1) × 16 words. Loading a new definition restarts the write pointer at the new base. While the base is zero the queue is considered undefined: pushes are accepted at the input and discarded, so nothing reaches memory.

A two-entry buffer sits between the sources and the memory port. When both sources push in the same cycle, the acknowledge source wins. A source whose push cannot be taken sees its ready low and keeps its request up, so no entry is lost.

Top module: `irq_queue_writer`

## Requirements
- R1: Bit 31 of every word presented on `mem_wdata` while `mem_we` is high is 1.
- R2: While the queue base is zero, pushes are accepted and discarded: `mem_we` stays low and `irq` stays low.
- R3: Successive writes go to successive word addresses, each 4 bytes above the last. When the next address would reach base + (blocks + 1) × 64 bytes, it wraps to the base.
- R4: An acknowledge entry is the word 0x0000_8000 (bit 15 set). A frame-indication entry is 0x0000_1000 with the channel number in bits [4:0]. Both appear with bit 31 added.
- R5: A `cfg_load` pulse captures the new base and size, and the next write goes to the new base.
- R6: When `ack_valid` is high, `fi_ready` is low, so the acknowledge source takes priority.
- R7: With two entries buffered, both ready outputs are low. A stalled push is taken later and is written, never dropped.
- R8: While `mem_we` is high and `mem_ack` is low, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R9: `irq` is high for exactly the one cycle that follows each cycle in which `mem_we` and `mem_ack` are both high.
- R10: Entries are written in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load a new queue definition |
| cfg_base | input | ADDR_W | Queue base byte address; zero means no queue |
| cfg_blocks | input | BLK_W | Queue size in 16-word blocks, minus one |
| ack_valid | input | 1 | Acknowledge entry push request |
| ack_ready | output | 1 | Acknowledge push accepted this cycle |
| fi_valid | input | 1 | Frame-indication entry push request |
| fi_chan | input | CHAN_W | Channel number of the frame indication |
| fi_ready | output | 1 | Frame-indication push accepted this cycle |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory write byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts the write this cycle |
| irq | output | 1 | One-cycle interrupt after each completed write |

## Verification
A push accepted at clock edge E makes `mem_we`, `mem_addr` and `mem_wdata` valid directly after E, provided the buffer was empty. If `mem_ack` is high at edge E+1, the write completes there and `irq` is high between E+1 and E+2. The ready outputs are combinational, so they are checked before the edge at which they matter. The bench drives inputs and samples outputs on falling edges only. Each check sits at the falling edge that follows the edge at which the result is due. In the stall sequence `mem_ack` is held low on purpose, so the bench can count buffered entries edge by edge before releasing the writes.

// File: rtl/irq_queue_writer.sv
module irq_queue_writer #(
  parameter int ADDR_W = 32,
  parameter int CHAN_W = 5,
  parameter int BLK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [BLK_W-1:0]  cfg_blocks,
  input  logic              ack_valid,
  output logic              ack_ready,
  input  logic              fi_valid,
  input  logic [CHAN_W-1:0] fi_chan,
  output logic              fi_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  output logic              irq
);

  localparam int SPAN_W = ADDR_W + 1;
  localparam logic [31:0] ACK_WORD = 32'h0000_8000;
  localparam logic [31:0] FI_FLAG  = 32'h0000_1000;
  localparam logic [31:0] INT_FLAG = 32'h8000_0000;

  logic [ADDR_W-1:0] q_base, cur;
  logic [SPAN_W-1:0] q_end, next_addr, blk_bytes;
  logic [31:0]       slot [2];
  logic [31:0]       push_word;
  logic              wp, rp;
  logic [1:0]        cnt;
  logic              irq_q;
  logic              full, empty, on, push, store, done, wrap;

  assign full  = (cnt == 2'd2);
  assign empty = (cnt == 2'd0);
  assign on    = (q_base != '0);

  assign ack_ready = !full;
  assign fi_ready  = !full && !ack_valid;

  assign push  = (ack_valid && ack_ready) || (fi_valid && fi_ready);
  assign store = push && on;
  assign push_word = ack_valid ? ACK_WORD
                               : (FI_FLAG | {{(32-CHAN_W){1'b0}}, fi_chan});

  assign mem_we    = !empty && on;
  assign mem_addr  = cur;
  assign mem_wdata = slot[rp] | INT_FLAG;
  assign done      = mem_we && mem_ack;
  assign irq       = irq_q;

  assign next_addr = {1'b0, cur} + SPAN_W'(4);
  assign wrap      = (next_addr >= q_end);
  assign blk_bytes = (SPAN_W'(cfg_blocks) + SPAN_W'(1)) << 6;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_base <= '0;
      q_end  <= '0;
      cur    <= '0;
    end else if (cfg_load) begin
      q_base <= cfg_base;
      q_end  <= {1'b0, cfg_base} + blk_bytes;
      cur    <= cfg_base;
    end else if (done) begin
      cur <= wrap ? q_base : next_addr[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= 1'b0;
      rp    <= 1'b0;
      cnt   <= 2'd0;
      irq_q <= 1'b0;
      slot[0] <= '0;
      slot[1] <= '0;
    end else begin
      irq_q <= done;
      if (store) begin
        slot[wp] <= push_word;
        wp       <= !wp;
      end
      if (done) rp <= !rp;
      case ({store, done})
        2'b10:   cnt <= cnt + 2'd1;
        2'b01:   cnt <= cnt - 2'd1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_int_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata[31]);

  p_no_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (q_base != '0));

  p_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (({1'b0, mem_addr} >= {1'b0, q_base}) && ({1'b0, mem_addr} < q_end)));

  p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !fi_ready);

  p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd2) |-> (!ack_ready && !fi_ready));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_ack && !cfg_load) |=>
      (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_ack) |=> irq);

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_ack) |=> !irq);

endmodule

// File: tb/sim_irq_queue_writer.sv
module sim_irq_queue_writer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;
  // [5] = 1 for acknowledge entry, [4:0] = channel for frame indication
  localparam logic [5:0] VEC [NV] = '{
    6'h20, 6'h00, 6'h01, 6'h1f, 6'h20, 6'h0a, 6'h15, 6'h20, 6'h02,
    6'h03, 6'h11, 6'h20, 6'h20, 6'h07, 6'h1e, 6'h10, 6'h20, 6'h05
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_load;
  logic [31:0] cfg_base;
  logic [7:0] cfg_blocks;
  logic ack_valid, ack_ready, fi_valid, fi_ready;
  logic [4:0] fi_chan;
  logic mem_we, mem_ack, irq;
  logic [31:0] mem_addr, mem_wdata;

  int n_checks = 0;
  int n_fail = 0;
  bit done_all = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_queue_writer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_blocks(cfg_blocks), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .fi_valid(fi_valid), .fi_chan(fi_chan), .fi_ready(fi_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_all) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_base = '0; cfg_blocks = '0;
    ack_valid = 1'b0; fi_valid = 1'b0; fi_chan = '0; mem_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc();
    chk(mem_we == 1'b0, "reset mem_we", 32'(mem_we), 0);
    chk(irq == 1'b0, "reset irq", 32'(irq), 0);
    chk(ack_ready && fi_ready, "reset R7 ready", {ack_ready, fi_ready}, 3);

    // R2: zero base, push discarded
    mem_ack = 1'b1;
    ack_valid = 1'b1;
    cyc();
    ack_valid = 1'b0;
    fi_valid = 1'b1; fi_chan = 5'd4;
    cyc();
    fi_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(!mem_we && !irq, "R2 zero base writes", {mem_we, irq}, 0);
      cyc();
    end

    // configure: base 0x1000, 16 words
    cfg_load = 1'b1; cfg_base = 32'h1000; cfg_blocks = 8'd0;
    cyc();
    cfg_load = 1'b0;
    chk(!mem_we, "R2 discarded entries not written", 32'(mem_we), 0);

    // table walk, R1 R3 R4 R9
    for (int i = 0; i < NV; i++) begin
      logic [31:0] exp_d, exp_a;
      exp_d = VEC[i][5] ? 32'h8000_8000 : (32'h8000_1000 | 32'(VEC[i][4:0]));
      exp_a = 32'h1000 + 32'((i % 16) * 4);
      if (VEC[i][5]) ack_valid = 1'b1;
      else begin fi_valid = 1'b1; fi_chan = VEC[i][4:0]; end
      cyc();
      ack_valid = 1'b0; fi_valid = 1'b0;
      chk(irq == 1'b0, "R9 irq single pulse", 32'(irq), 0);
      chk(mem_we == 1'b1, "R1 write issued", 32'(mem_we), 1);
      chk(mem_addr == exp_a, "R3 address/wrap", mem_addr, exp_a);
      chk(mem_wdata == exp_d, "R4 R1 word", mem_wdata, exp_d);
      cyc();
      chk(irq == 1'b1, "R9 irq after write", 32'(irq), 1);
      chk(mem_we == 1'b0, "R9 queue drained", 32'(mem_we), 0);
    end

    // stall sequence: R6 R7 R8 R10
    mem_ack = 1'b0;
    ack_valid = 1'b1; fi_valid = 1'b1; fi_chan = 5'd3;
    #1;
    chk(fi_ready == 1'b0, "R6 fi blocked by ack", 32'(fi_ready), 0);
    chk(ack_ready == 1'b1, "R6 ack ready", 32'(ack_ready), 1);
    cyc();
    ack_valid = 1'b0;
    #1;
    chk(fi_ready == 1'b1, "R6 fi ready after ack", 32'(fi_ready), 1);
    chk(mem_addr == 32'h1008, "R3 addr after wrap run", mem_addr, 32'h1008);
    chk(mem_wdata == 32'h8000_8000, "R6 ack written first", mem_wdata, 32'h8000_8000);
    cyc();
    fi_valid = 1'b0; ack_valid = 1'b1;
    #1;
    chk(!ack_ready && !fi_ready, "R7 full stall", {ack_ready, fi_ready}, 0);
    cyc();
    chk(mem_we && mem_addr == 32'h1008, "R8 addr held", mem_addr, 32'h1008);
    chk(mem_wdata == 32'h8000_8000, "R8 data held", mem_wdata, 32'h8000_8000);
    chk(irq == 1'b0, "R9 no irq while stalled", 32'(irq), 0);
    mem_ack = 1'b1;
    cyc();
    chk(irq == 1'b1, "R9 irq on release", 32'(irq), 1);
    chk(mem_addr == 32'h100c, "R10 second addr", mem_addr, 32'h100c);
    chk(mem_wdata == 32'h8000_1003, "R10 fi second", mem_wdata, 32'h8000_1003);
    cyc();
    ack_valid = 1'b0;
    chk(mem_addr == 32'h1010, "R7 stalled push addr", mem_addr, 32'h1010);
    chk(mem_wdata == 32'h8000_8000, "R7 stalled push kept", mem_wdata, 32'h8000_8000);
    cyc();
    chk(irq && !mem_we, "R7 drained", {irq, mem_we}, 2);

    // R5 reload
    cfg_load = 1'b1; cfg_base = 32'h2000; cfg_blocks = 8'd1;
    cyc();
    cfg_load = 1'b0;
    fi_valid = 1'b1; fi_chan = 5'd31;
    cyc();
    fi_valid = 1'b0;
    chk(mem_addr == 32'h2000, "R5 new base", mem_addr, 32'h2000);
    chk(mem_wdata == 32'h8000_101f, "R4 max channel", mem_wdata, 32'h8000_101f);
    cyc();
    chk(irq == 1'b1, "R9 irq after reload write", 32'(irq), 1);

    done_all = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule